// File: doc/BRIEF.md
# Multiply-accumulate unit with split HI/LO accumulator

This block executes a family of 32x32 multiply operations against a pair of 64-bit registers, HI and LO. For the 32-bit family, the working accumulator is 64 bits wide: its upper half is held in HI[31:0] and its lower half in LO[31:0]. Each operation multiplies the low 32 bits of two source operands, signed or unsigned. It then does one of four things with the product: loads it, loads its negation, adds it to the accumulator, or subtracts it from the accumulator. The add forms can saturate. Most forms also return one half of the new accumulator, sign-extended to 64 bits, as a write-back value for a destination register.

A separate doubleword family adds the product to the whole 64-bit LO register. It leaves HI alone and produces no write-back.

Operations arrive on a valid/ready stream. `in_ready` is held high, so the block never applies back-pressure, and every cycle with `in_valid` high consumes exactly one operation. Results appear in the cycle after acceptance. In that cycle the block raises `done` for one cycle, updates HI and LO, and drives `wb_en`/`wb_data`. The result side has no ready: the consumer must take the write-back in the cycle it is presented.

Top module: `mac_hilo_unit`

## Requirements
- R1: A 32-bit-family operation writes only HI[31:0] (accumulator bits 63:32) and LO[31:0] (accumulator bits 31:0). HI[63:32] never changes after reset, and LO[63:32] is changed only by the doubleword family.
- R2: The product uses src_a[31:0] and src_b[31:0] only. Signed forms sign-extend both operands and unsigned forms zero-extend them. A form is unsigned when `op_sub[0]` is 1 (function 101000 or 101001) or when `op_func` is 011001.
- R3: With function 101000, sub-opcodes 00100 and 00101 (move LO), and 01100 and 01101 (move HI), load the accumulator with the product.
- R4: With function 101000, sub-opcodes 00000, 00001, 10000, 10001, 01000, 01001, 11000 and 11001 add the product to the accumulator. Sub-opcode bit 4 selects saturation.
- R5: With function 011000 (signed) or 011001 (unsigned), the sub-opcodes do the following. 00011 and 01011 load the negated product. 00111 and 01111 subtract the product from the accumulator.
- R6: For every 32-bit-family form, `wb_data` is bits 31:0 of the new accumulator when sub-opcode bit 3 is 0, and bits 63:32 when it is 1. In both cases the value is sign-extended to 64 bits.
- R7: For signed saturating forms, a 64-bit result above 0x7FFFFFFF becomes 0x7FFFFFFF, and a result below -2^31 becomes 0xFFFFFFFF80000000.
- R8: For unsigned saturating forms, a result above 0x7FFFFFFF becomes all ones.
- R9: Function 101001 with sub-opcodes 00000, 00001, 10000 or 10001 adds the product to the full 64-bit LO, with saturation when sub-opcode bit 4 is 1. These forms leave HI unchanged and do not raise `wb_en`.
- R10: Any other function/sub-opcode pair raises `illegal` for one cycle. In that case HI, LO and the write-back stay unchanged.
- R11: `wb_en` stays low when `dst_idx` is 0. Otherwise `wb_idx` carries the accepted `dst_idx`.
- R12: After reset, HI, LO and all flags are zero. `done` is high exactly in the cycle after an accepted operation. With `in_valid` low, HI and LO hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation valid |
| in_ready | output | 1 | Always 1; the block never stalls |
| op_sub | input | 5 | Sub-opcode field selecting the variant |
| op_func | input | 6 | Function field selecting the family |
| src_a | input | 64 | First source operand |
| src_b | input | 64 | Second source operand |
| dst_idx | input | 5 | Destination register index |
| hi_q | output | 64 | HI register |
| lo_q | output | 64 | LO register |
| done | output | 1 | One-cycle pulse after each accepted operation |
| illegal | output | 1 | The accepted operation was not recognised |
| wb_en | output | 1 | Write-back valid |
| wb_idx | output | 5 | Write-back destination index |
| wb_data | output | 64 | Sign-extended write-back value |

## Verification
The hardest case to reach is a saturating accumulate whose clamp depends on accumulator state left by earlier operations. The stimulus builds that state with deliberate sequences: a plain multiply that leaves 0x80000000 in the accumulator, and a negate that leaves -2^31. It then issues saturating adds that push the sum just past each bound. Non-zero upper halves of LO, needed to show that 32-bit forms preserve them, can only be produced by a doubleword accumulate, so that is issued first. A pseudo-random mix of every legal code, some illegal codes and a destination of zero follows. A behavioural model in the bench checks that mix on every clock.

// File: rtl/mac_pkg.sv
`timescale 1ns/1ps
package mac_pkg;
  typedef enum logic [2:0] {
    K_MUL = 3'd0,
    K_NEG = 3'd1,
    K_ACC = 3'd2,
    K_SUB = 3'd3,
    K_DWD = 3'd4
  } mac_kind_e;

  typedef struct packed {
    logic      legal;
    mac_kind_e kind;
    logic      uns;
    logic      sat;
    logic      hisel;
  } mac_ctl_t;

  localparam logic [5:0] FN_ACC32 = 6'b101000;
  localparam logic [5:0] FN_ACC64 = 6'b101001;
  localparam logic [5:0] FN_NEG_S = 6'b011000;
  localparam logic [5:0] FN_NEG_U = 6'b011001;
endpackage

// File: rtl/mac_decode.sv
`timescale 1ns/1ps
module mac_decode
  import mac_pkg::*;
(
  input  logic [4:0] sub,
  input  logic [5:0] func,
  output mac_ctl_t   ctl
);
  always_comb begin
    ctl = '0;
    unique case (func)
      FN_ACC32: begin
        unique case (sub)
          5'b00000, 5'b00001, 5'b10000, 5'b10001,
          5'b01000, 5'b01001, 5'b11000, 5'b11001: begin
            ctl.legal = 1'b1;
            ctl.kind  = K_ACC;
            ctl.sat   = sub[4];
          end
          5'b00100, 5'b00101, 5'b01100, 5'b01101: begin
            ctl.legal = 1'b1;
            ctl.kind  = K_MUL;
          end
          default: ctl.legal = 1'b0;
        endcase
        ctl.uns   = sub[0];
        ctl.hisel = sub[3];
      end
      FN_ACC64: begin
        unique case (sub)
          5'b00000, 5'b00001, 5'b10000, 5'b10001: begin
            ctl.legal = 1'b1;
            ctl.kind  = K_DWD;
            ctl.sat   = sub[4];
          end
          default: ctl.legal = 1'b0;
        endcase
        ctl.uns = sub[0];
      end
      FN_NEG_S, FN_NEG_U: begin
        unique case (sub)
          5'b00011, 5'b01011: begin
            ctl.legal = 1'b1;
            ctl.kind  = K_NEG;
          end
          5'b00111, 5'b01111: begin
            ctl.legal = 1'b1;
            ctl.kind  = K_SUB;
          end
          default: ctl.legal = 1'b0;
        endcase
        ctl.uns   = func[0];
        ctl.hisel = sub[3];
      end
      default: ctl = '0;
    endcase
  end
endmodule

// File: rtl/mac_mult.sv
`timescale 1ns/1ps
module mac_mult #(
  parameter int HW = 32
) (
  input  logic [HW-1:0]   opa,
  input  logic [HW-1:0]   opb,
  input  logic            uns,
  output logic [2*HW-1:0] prod
);
  localparam int EW = HW + 1;
  logic signed [EW-1:0]   ea, eb;
  logic signed [2*EW-1:0] full;

  assign ea   = $signed({~uns & opa[HW-1], opa});
  assign eb   = $signed({~uns & opb[HW-1], opb});
  assign full = ea * eb;
  assign prod = full[2*HW-1:0];
endmodule

// File: rtl/mac_sum.sv
`timescale 1ns/1ps
module mac_sum #(
  parameter int W = 64
) (
  input  logic [W-1:0] base,
  input  logic [W-1:0] prod,
  input  logic         negate,
  input  logic         sat,
  input  logic         uns,
  output logic [W-1:0] result
);
  localparam int HW = W / 2;
  localparam logic [W-1:0] MAX_POS = {{(W-HW+1){1'b0}}, {(HW-1){1'b1}}};
  localparam logic [W-1:0] MIN_NEG = {{(W-HW+1){1'b1}}, {(HW-1){1'b0}}};

  logic [W-1:0] raw;
  assign raw = negate ? (base - prod) : (base + prod);

  always_comb begin
    result = raw;
    if (sat) begin
      if (uns) begin
        if (raw > MAX_POS) result = '1;
      end else if ($signed(raw) > $signed(MAX_POS)) begin
        result = MAX_POS;
      end else if ($signed(raw) < $signed(MIN_NEG)) begin
        result = MIN_NEG;
      end
    end
  end
endmodule

// File: rtl/mac_hilo_unit.sv
`timescale 1ns/1ps
module mac_hilo_unit
  import mac_pkg::*;
#(
  parameter int W    = 64,
  parameter int IDXW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [4:0]      op_sub,
  input  logic [5:0]      op_func,
  input  logic [W-1:0]    src_a,
  input  logic [W-1:0]    src_b,
  input  logic [IDXW-1:0] dst_idx,
  output logic [W-1:0]    hi_q,
  output logic [W-1:0]    lo_q,
  output logic            done,
  output logic            illegal,
  output logic            wb_en,
  output logic [IDXW-1:0] wb_idx,
  output logic [W-1:0]    wb_data
);
  localparam int HW = W / 2;

  mac_ctl_t     ctl;
  logic [W-1:0] prod, acc, base, nxt, wb_val;
  logic         negate;
  logic         unused_hi_src;

  assign in_ready      = 1'b1;
  assign unused_hi_src = ^{src_a[W-1:HW], src_b[W-1:HW]};

  mac_decode u_dec (.sub(op_sub), .func(op_func), .ctl(ctl));

  mac_mult #(.HW(HW)) u_mul (
    .opa(src_a[HW-1:0]), .opb(src_b[HW-1:0]), .uns(ctl.uns), .prod(prod)
  );

  assign acc    = {hi_q[HW-1:0], lo_q[HW-1:0]};
  assign negate = (ctl.kind == K_NEG) || (ctl.kind == K_SUB);

  always_comb begin
    unique case (ctl.kind)
      K_DWD:        base = lo_q;
      K_MUL, K_NEG: base = '0;
      default:      base = acc;
    endcase
  end

  mac_sum #(.W(W)) u_sum (
    .base(base), .prod(prod), .negate(negate),
    .sat(ctl.sat), .uns(ctl.uns), .result(nxt)
  );

  assign wb_val = ctl.hisel ? {{HW{nxt[W-1]}}, nxt[W-1:HW]}
                            : {{HW{nxt[HW-1]}}, nxt[HW-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q    <= '0;
      lo_q    <= '0;
      done    <= 1'b0;
      illegal <= 1'b0;
      wb_en   <= 1'b0;
      wb_idx  <= '0;
      wb_data <= '0;
    end else begin
      done    <= in_valid;
      illegal <= in_valid && !ctl.legal;
      wb_en   <= 1'b0;
      if (in_valid && ctl.legal) begin
        if (ctl.kind == K_DWD) begin
          lo_q <= nxt;
        end else begin
          hi_q[HW-1:0] <= nxt[W-1:HW];
          lo_q[HW-1:0] <= nxt[HW-1:0];
          wb_en        <= (dst_idx != '0);
          wb_idx       <= dst_idx;
          wb_data      <= wb_val;
        end
      end
    end
  end
endmodule

// File: rtl/mac_hilo_unit_chk.sv
`timescale 1ns/1ps
module mac_hilo_unit_chk #(
  parameter int W    = 64,
  parameter int IDXW = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [W-1:0]    hi_q,
  input logic [W-1:0]    lo_q,
  input logic            done,
  input logic            illegal,
  input logic            wb_en,
  input logic [IDXW-1:0] wb_idx,
  input logic [W-1:0]    wb_data
);
  localparam int HW = W / 2;

  a_r1_hi_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(hi_q[W-1:HW]));

  a_r6_wb_sign_ext: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (wb_data[W-1:HW] == {HW{wb_data[HW-1]}}));

  a_r10_illegal_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!wb_en && hi_q == $past(hi_q) && lo_q == $past(lo_q)));

  a_r11_no_wb_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (wb_idx != '0));

  a_r12_done_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> done);

  a_r12_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!done && !illegal && !wb_en && $stable(hi_q) && $stable(lo_q)));
endmodule

bind mac_hilo_unit mac_hilo_unit_chk #(.W(W), .IDXW(IDXW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .hi_q(hi_q), .lo_q(lo_q),
  .done(done), .illegal(illegal), .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data)
);

// File: tb/mac_hilo_unit_bench.sv
`timescale 1ns/1ps
module mac_hilo_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [4:0]  op_sub = '0;
  logic [5:0]  op_func = '0;
  logic [63:0] src_a = '0, src_b = '0;
  logic [4:0]  dst_idx = '0;
  logic [63:0] hi_q, lo_q, wb_data;
  logic        done, illegal, wb_en;
  logic [4:0]  wb_idx;

  int n_run = 0, n_fail = 0;
  logic [63:0] m_hi = '0, m_lo = '0;

  always #2.5 clk = ~clk;

  mac_hilo_unit u_mac_hilo_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_sub(op_sub), .op_func(op_func), .src_a(src_a), .src_b(src_b),
    .dst_idx(dst_idx), .hi_q(hi_q), .lo_q(lo_q), .done(done),
    .illegal(illegal), .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data)
  );

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic issue(input bit v, input logic [5:0] fn, input logic [4:0] sb,
                       input logic [63:0] a, input logic [63:0] b,
                       input logic [4:0] d, input string tag);
    bit ok = 0, uns = 0, sat = 0, hs = 0;
    int kind = 0;
    logic [63:0] p, acc, r, e_wb;
    longint sr;
    bit e_en;
    @(negedge clk);
    in_valid = v; op_func = fn; op_sub = sb; src_a = a; src_b = b; dst_idx = d;
    if (fn == 6'b101000) begin
      case (sb)
        5'b00000: begin ok = 1; kind = 2; end
        5'b00001: begin ok = 1; kind = 2; uns = 1; end
        5'b10000: begin ok = 1; kind = 2; sat = 1; end
        5'b10001: begin ok = 1; kind = 2; sat = 1; uns = 1; end
        5'b01000: begin ok = 1; kind = 2; hs = 1; end
        5'b01001: begin ok = 1; kind = 2; hs = 1; uns = 1; end
        5'b11000: begin ok = 1; kind = 2; hs = 1; sat = 1; end
        5'b11001: begin ok = 1; kind = 2; hs = 1; sat = 1; uns = 1; end
        5'b00100: begin ok = 1; kind = 0; end
        5'b00101: begin ok = 1; kind = 0; uns = 1; end
        5'b01100: begin ok = 1; kind = 0; hs = 1; end
        5'b01101: begin ok = 1; kind = 0; hs = 1; uns = 1; end
        default: ok = 0;
      endcase
    end else if (fn == 6'b101001) begin
      case (sb)
        5'b00000: begin ok = 1; kind = 4; end
        5'b00001: begin ok = 1; kind = 4; uns = 1; end
        5'b10000: begin ok = 1; kind = 4; sat = 1; end
        5'b10001: begin ok = 1; kind = 4; sat = 1; uns = 1; end
        default: ok = 0;
      endcase
    end else if (fn == 6'b011000 || fn == 6'b011001) begin
      uns = (fn == 6'b011001);
      case (sb)
        5'b00011: begin ok = 1; kind = 1; end
        5'b01011: begin ok = 1; kind = 1; hs = 1; end
        5'b00111: begin ok = 1; kind = 3; end
        5'b01111: begin ok = 1; kind = 3; hs = 1; end
        default: ok = 0;
      endcase
    end
    if (uns) p = {32'd0, a[31:0]} * {32'd0, b[31:0]};
    else     p = {{32{a[31]}}, a[31:0]} * {{32{b[31]}}, b[31:0]};
    acc = {m_hi[31:0], m_lo[31:0]};
    case (kind)
      0: r = p;
      1: r = 64'd0 - p;
      2: r = acc + p;
      3: r = acc - p;
      default: r = m_lo + p;
    endcase
    if (sat) begin
      sr = r;
      if (uns) begin
        if (r > 64'h7FFFFFFF) r = '1;
      end else if (sr > 64'sd2147483647) r = 64'h7FFFFFFF;
      else if (sr < -64'sd2147483648) r = 64'hFFFFFFFF80000000;
    end
    e_en = 0; e_wb = 'x;
    if (v && ok) begin
      if (kind == 4) m_lo = r;
      else begin
        m_hi[31:0] = r[63:32];
        m_lo[31:0] = r[31:0];
        e_en = (d != 0);
        e_wb = hs ? {{32{r[63]}}, r[63:32]} : {{32{r[31]}}, r[31:0]};
      end
    end
    @(posedge clk);
    #1;
    chk(tag, "hi", hi_q, m_hi);
    chk(tag, "lo", lo_q, m_lo);
    chk(tag, "done", {63'd0, done}, {63'd0, v});
    chk(tag, "illegal", {63'd0, illegal}, {63'd0, v && !ok});
    chk(tag, "wb_en", {63'd0, wb_en}, {63'd0, e_en});
    if (e_en) begin
      chk(tag, "wb_data", wb_data, e_wb);
      chk(tag, "wb_idx", {59'd0, wb_idx}, {59'd0, d});
    end
  endtask

  localparam logic [10:0] CODES [0:23] = '{
    {6'b101000,5'b00000}, {6'b101000,5'b00001}, {6'b101000,5'b10000},
    {6'b101000,5'b10001}, {6'b101000,5'b01000}, {6'b101000,5'b01001},
    {6'b101000,5'b11000}, {6'b101000,5'b11001}, {6'b101000,5'b00100},
    {6'b101000,5'b00101}, {6'b101000,5'b01100}, {6'b101000,5'b01101},
    {6'b101001,5'b00000}, {6'b101001,5'b00001}, {6'b101001,5'b10000},
    {6'b101001,5'b10001}, {6'b011000,5'b00011}, {6'b011000,5'b01011},
    {6'b011000,5'b00111}, {6'b011000,5'b01111}, {6'b011001,5'b00011},
    {6'b011001,5'b01011}, {6'b011001,5'b00111}, {6'b011001,5'b01111}
  };

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] rnd = 32'h1234_5678;
    repeat (3) @(posedge clk);
    #1;
    chk("R12", "reset hi", hi_q, 64'd0);
    chk("R12", "reset lo", lo_q, 64'd0);
    chk("R12", "reset flags", {60'd0, done, illegal, wb_en, in_ready}, 64'd1);
    @(negedge clk); rst_n = 1'b1;

    issue(1, 6'b101000, 5'b00100, 64'hFFFF_0000_FFFF_FFFD, 64'd5, 5'd7, "R3");
    issue(1, 6'b101000, 5'b01101, 64'hAAAA_AAAA_FFFF_FFFF, 64'd2, 5'd3, "R2");
    issue(1, 6'b101000, 5'b01100, 64'h0000_0000_FFFF_FFFF, 64'd2, 5'd3, "R2");
    issue(1, 6'b101001, 5'b00001, 64'hFFFF_FFFF, 64'hFFFF_FFFF, 5'd4, "R9");
    issue(1, 6'b101000, 5'b00000, 64'd1000, 64'd1000, 5'd9, "R1");
    issue(1, 6'b101000, 5'b01000, 64'h7FFF_FFFF, 64'h7FFF_FFFF, 5'd9, "R4");
    issue(1, 6'b101000, 5'b00001, 64'hFFFF_FFFF, 64'h10, 5'd9, "R4");
    issue(1, 6'b011000, 5'b00011, 64'd6, 64'd7, 5'd1, "R5");
    issue(1, 6'b011001, 5'b01011, 64'hFFFF_FFFF, 64'd3, 5'd1, "R5");
    issue(1, 6'b011000, 5'b00111, 64'd100, 64'hFFFF_FFFF, 5'd2, "R5");
    issue(1, 6'b011001, 5'b01111, 64'h8000_0000, 64'd4, 5'd2, "R6");
    issue(1, 6'b101000, 5'b00100, 64'h4000_0000, 64'd2, 5'd5, "R7");
    issue(1, 6'b101000, 5'b10000, 64'd0, 64'd0, 5'd5, "R7");
    issue(1, 6'b011000, 5'b00011, 64'h4000_0000, 64'd2, 5'd5, "R7");
    issue(1, 6'b101000, 5'b11000, 64'hFFFF_FFFF, 64'd1, 5'd5, "R7");
    issue(1, 6'b101000, 5'b00101, 64'h1_0000, 64'h1_0000, 5'd6, "R8");
    issue(1, 6'b101000, 5'b10001, 64'd0, 64'd0, 5'd6, "R8");
    issue(1, 6'b101000, 5'b00101, 64'd3, 64'd3, 5'd6, "R8");
    issue(1, 6'b101000, 5'b11001, 64'd2, 64'd2, 5'd6, "R8");
    issue(1, 6'b101001, 5'b10000, 64'h7FFF_FFFF, 64'h7FFF_FFFF, 5'd8, "R9");
    issue(1, 6'b101001, 5'b10001, 64'd1, 64'd1, 5'd8, "R9");
    issue(1, 6'b101000, 5'b00010, 64'd9, 64'd9, 5'd8, "R10");
    issue(1, 6'b000000, 5'b00000, 64'd9, 64'd9, 5'd8, "R10");
    issue(1, 6'b011000, 5'b00000, 64'd9, 64'd9, 5'd8, "R10");
    issue(1, 6'b101000, 5'b00100, 64'd11, 64'd13, 5'd0, "R11");
    issue(0, 6'b101000, 5'b00100, 64'd5, 64'd5, 5'd3, "R12");
    issue(0, 6'b000000, 5'b00000, 64'd0, 64'd0, 5'd0, "R12");

    for (int i = 0; i < 200; i++) begin
      logic [10:0] c;
      logic [63:0] a, b;
      rnd = rnd ^ (rnd << 13); rnd = rnd ^ (rnd >> 17); rnd = rnd ^ (rnd << 5);
      c = CODES[rnd % 24];
      if (rnd[27:25] == 3'd0) c = {rnd[14:9], rnd[4:0]};
      a = {rnd, rnd ^ 32'h5A5A_0F0F};
      rnd = rnd ^ (rnd << 13); rnd = rnd ^ (rnd >> 17); rnd = rnd ^ (rnd << 5);
      b = {~rnd, rnd};
      issue(rnd[30:28] != 3'd0, c[10:5], c[4:0], a, b, rnd[20:16], "R2");
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule